// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Controller

This block is a synchronous serial controller that runs either as the clock-generating master or as a follower of an external serial clock. One shift register sends the outgoing character MSB first and collects the incoming character at the same time. A transmit holding register sits in front of the shift register. When a character finishes, the held character moves into the shift register at once, so characters can follow each other with no gap. The last complete received character stays in a receive register until the next one arrives.

Software reaches the block through a small register bus. A read of the status register is combinational. A write takes effect on the clock edge where the write strobe is high. A read strobe on the receive address has a side effect, but a read of the separate debug address returns the same received character and changes no flag. One interrupt line combines the completion flag and the overrun flag, each under its own enable. The serial data output carries MOSI in master mode and MISO in slave mode. The system routes it to the right pin.

Top module: `spi_duplex_ctrl`

## Requirements
- R1: The register map is: address 0 control, address 1 status, address 2 divider, address 3 transmit (write), address 4 receive (read, clears flags), address 5 receive debug copy (read, no side effect). Control bits are bit0 master, bit1 phase, bit2 transmit enable, bit3 completion interrupt enable, bit4 overrun interrupt enable, and they read back as written. The divider register keeps 7 bits, so writing 0xFF reads back 0x7F.
- R2: In master mode one serial bit lasts 2×(divider+1) system clocks when the divider is 3 or more, and 8 system clocks when it is below 3. The serial clock idles low.
- R3: Characters are sent MSB first. Each sample edge shifts one received bit into the LSB end, so with the data output looped to the data input the received character equals the sent one.
- R4: With phase=1 the first data bit is valid before the first rising serial clock edge, data is sampled on rising edges, and data changes on falling edges. With phase=0 data changes on rising edges and is sampled on falling edges.
- R5: A transmit write sets transmit-full (status bit 2). Moving the character into the shift register clears it. A character written while one is being shifted starts right after it with no idle bit time.
- R6: A master transfer starts only while transmit enable is set. With it clear, a held character stays pending and the serial clock stays low.
- R7: The completion flag (status bit 0) sets when a character finishes. A read of the receive register clears both the completion flag and the overrun flag.
- R8: When a character finishes while the completion flag is still set, the overrun flag (status bit 1) sets and the new character replaces the receive register.
- R9: A read of the debug address returns the receive register and leaves every flag unchanged.
- R10: The interrupt output is high when (completion flag AND its enable) OR (overrun flag AND its enable).
- R11: In slave mode the block shifts on edges of the external serial clock, ends a character after 8 sample edges, and holds its own serial clock output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_rdata | output | DW | Read data for bus_addr |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_in | input | 1 | Serial clock received in slave mode |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a character finishing while the previous one is still unread, together with a gapless hand-over from the holding register. The stimulus gets there by polling status until transmit-full drops and then writing the second character at once, while the first is still shifting. No receive read is issued, so the second completion lands on an unread buffer. The timestamps of the serial clock rising edges across both characters then show whether any idle bit time was inserted.

// File: rtl/spi_dup_pkg.sv
package spi_dup_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TX   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RX   = 3'd4;
  localparam logic [ADDR_W-1:0] A_DBG  = 3'd5;

  localparam int C_MST    = 0;
  localparam int C_PHA    = 1;
  localparam int C_TXEN   = 2;
  localparam int C_IEDONE = 3;
  localparam int C_IEOVR  = 4;
  localparam int CTRL_W   = 5;
  localparam int DIV_W    = 7;

  // system clocks per half serial bit
  function automatic logic [7:0] half_clocks(input logic [DIV_W-1:0] dv);
    if (dv < 7'd3) return 8'd4;
    return {1'b0, dv} + 8'd1;
  endfunction
endpackage

// File: rtl/spi_mclk.sv
module spi_mclk
  import spi_dup_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] divider,
  output logic             busy,
  output logic             sck,
  output logic             rise,
  output logic             fall,
  output logic             last
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES);

  logic [7:0]    hcnt;
  logic [EW-1:0] ecnt;
  logic [7:0]    half;
  logic          tick;

  assign half = half_clocks(divider);
  assign tick = busy && (hcnt == half - 8'd1);
  assign rise = tick && !sck;
  assign fall = tick && sck;
  assign last = tick && (ecnt == EW'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sck  <= 1'b0;
      hcnt <= '0;
      ecnt <= '0;
    end else if (go) begin
      busy <= 1'b1;
      sck  <= 1'b0;
      hcnt <= '0;
      ecnt <= '0;
    end else if (busy) begin
      if (tick) begin
        hcnt <= '0;
        sck  <= ~sck;
        ecnt <= ecnt + 1'b1;
        if (last) busy <= 1'b0;
      end else begin
        hcnt <= hcnt + 8'd1;
      end
    end
  end
endmodule

// File: rtl/spi_ssync.sv
module spi_ssync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic sdi,
  output logic rise,
  output logic fall,
  output logic sdi_s
);
  logic sck_m, sck_s, sck_d, sdi_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= 1'b0;
      sck_s <= 1'b0;
      sck_d <= 1'b0;
      sdi_m <= 1'b0;
      sdi_s <= 1'b0;
    end else begin
      sck_m <= sck_in;
      sck_s <= sck_m;
      sck_d <= sck_s;
      sdi_m <= sdi;
      sdi_s <= sdi_m;
    end
  end

  assign rise = sck_s && !sck_d;
  assign fall = !sck_s && sck_d;
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic          sample,
  input  logic          drive,
  input  logic          sdi,
  output logic          sdo,
  output logic          char_end,
  output logic          idle,
  output logic [DW-1:0] cap_word
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sr;
  logic [DW-1:0] shifted;
  logic [CW-1:0] cnt;

  assign shifted  = {sr[DW-2:0], sdi};
  assign char_end = sample && (cnt == CW'(DW - 1));
  assign idle     = (cnt == '0);
  assign cap_word = sample ? shifted : sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      sdo <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      sr  <= load_word;
      sdo <= load_word[DW-1];
      cnt <= '0;
    end else begin
      if (sample) begin
        sr  <= shifted;
        cnt <= char_end ? '0 : cnt + 1'b1;
      end
      if (drive) sdo <= sr[DW-1];
    end
  end
endmodule

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl
  import spi_dup_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic              sck_out,
  input  logic              sck_in,
  output logic              sdo,
  input  logic              sdi,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl;
  logic [DIV_W-1:0]  divider;
  logic [DW-1:0]     txbuf, rxbuf, cap_word;
  logic tx_full, done_flag, ovr_flag;
  logic master, phase, txen;
  logic tx_wr, rx_rd, dbg_rd;
  logic mst_busy, mst_sck, mst_rise, mst_fall, mst_last, mst_go;
  logic s_rise, s_fall, s_sdi;
  logic ev_rise, ev_fall, sample, drive, core_sdi;
  logic char_end, core_idle, slv_load, tx_load, xfer_done;

  assign master = ctrl[C_MST];
  assign phase  = ctrl[C_PHA];
  assign txen   = ctrl[C_TXEN];
  assign tx_wr  = bus_wr && (bus_addr == A_TX);
  assign rx_rd  = bus_rd && (bus_addr == A_RX);
  assign dbg_rd = bus_rd && (bus_addr == A_DBG);

  spi_mclk #(.DW(DW)) u_mclk (
    .clk(clk), .rst_n(rst_n), .go(mst_go), .divider(divider),
    .busy(mst_busy), .sck(mst_sck), .rise(mst_rise), .fall(mst_fall), .last(mst_last)
  );

  spi_ssync u_ssync (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sdi(sdi),
    .rise(s_rise), .fall(s_fall), .sdi_s(s_sdi)
  );

  assign ev_rise  = master ? mst_rise : s_rise;
  assign ev_fall  = master ? mst_fall : s_fall;
  assign core_sdi = master ? sdi : s_sdi;
  assign sample   = phase ? ev_rise : ev_fall;
  assign drive    = phase ? ev_fall : ev_rise;

  // master: start when idle or at the last edge of the current character
  assign mst_go   = master && txen && tx_full && (!mst_busy || mst_last);
  // slave: load between characters or right at the end of one
  assign slv_load = !master && tx_full &&
                    ((core_idle && !sample) || char_end);
  assign tx_load  = mst_go || slv_load;
  assign xfer_done = master ? mst_last : char_end;

  spi_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_word(txbuf),
    .sample(sample), .drive(drive), .sdi(core_sdi), .sdo(sdo),
    .char_end(char_end), .idle(core_idle), .cap_word(cap_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      divider   <= '0;
      txbuf     <= '0;
      tx_full   <= 1'b0;
      rxbuf     <= '0;
      done_flag <= 1'b0;
      ovr_flag  <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl    <= bus_wdata[CTRL_W-1:0];
      if (bus_wr && bus_addr == A_DIV)  divider <= bus_wdata[DIV_W-1:0];
      if (tx_wr) txbuf <= bus_wdata;

      if (tx_wr)        tx_full <= 1'b1;
      else if (tx_load) tx_full <= 1'b0;

      if (xfer_done) rxbuf <= cap_word;

      if (xfer_done)  done_flag <= 1'b1;
      else if (rx_rd) done_flag <= 1'b0;

      if (xfer_done && done_flag) ovr_flag <= 1'b1;
      else if (rx_rd)             ovr_flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:        bus_rdata[CTRL_W-1:0] = ctrl;
      A_STAT:        bus_rdata[2:0] = {tx_full, ovr_flag, done_flag};
      A_DIV:         bus_rdata[DIV_W-1:0] = divider;
      A_RX, A_DBG:   bus_rdata = rxbuf;
      default:       bus_rdata = '0;
    endcase
  end

  assign sck_out = master && mst_sck;
  assign irq = (done_flag && ctrl[C_IEDONE]) || (ovr_flag && ctrl[C_IEOVR]);
endmodule

// File: rtl/spi_duplex_chk.sv
module spi_duplex_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_done,
  input logic done_flag,
  input logic ovr_flag,
  input logic tx_full,
  input logic tx_load,
  input logic tx_wr,
  input logic mst_busy,
  input logic sck_out,
  input logic txen,
  input logic dbg_rd
);
  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(xfer_done));

  // R8
  ovr_needs_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(done_flag));

  // R5
  load_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !tx_wr) |=> !tx_full);

  // R6
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_busy) |-> $past(txen));

  // R2
  sck_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_out) |-> $past(mst_busy));

  // R9
  dbg_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rd && !xfer_done) |=> ($stable(done_flag) && $stable(ovr_flag)));
endmodule

bind spi_duplex_ctrl spi_duplex_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .done_flag(done_flag),
  .ovr_flag(ovr_flag), .tx_full(tx_full), .tx_load(tx_load), .tx_wr(tx_wr),
  .mst_busy(mst_busy), .sck_out(sck_out), .txen(txen), .dbg_rd(dbg_rd)
);

// File: tb/spi_duplex_ctrl_test.sv
`timescale 1ns/1ps
module spi_duplex_ctrl_test;
  localparam int DW = 8;
  localparam real TCLK = 5.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic sck_out, sdo, irq;
  logic sck_in = 1'b0, sdi_drv = 1'b0, loopback = 1'b1;
  logic sdi;

  int checks = 0, fails = 0;
  logic [DW-1:0] mon_pos = '0, mon_neg = '0;
  int rise_cnt = 0;
  realtime rt [64];

  always #(TCLK/2) clk = ~clk;
  assign sdi = loopback ? sdo : sdi_drv;

  spi_duplex_ctrl #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sck_out(sck_out), .sck_in(sck_in), .sdo(sdo), .sdi(sdi), .irq(irq)
  );

  always @(posedge sck_out) begin
    mon_pos = {mon_pos[DW-2:0], sdo};
    rt[rise_cnt % 64] = $realtime;
    rise_cnt++;
  end
  always @(negedge sck_out) mon_neg = {mon_neg[DW-2:0], sdo};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_status(input int bitpos, input logic val, input string req);
    logic [DW-1:0] s;
    int n = 0;
    do begin
      bus_read(3'd1, s);
      n++;
    end while (s[bitpos] !== val && n < 3000);
    chk(n < 3000, req, n, 0);
  endtask

  function automatic int bit_clocks(input int dv);
    return (dv < 3) ? 8 : 2 * (dv + 1);
  endfunction

  task automatic t_reset();
    logic [DW-1:0] d;
    bus_read(3'd0, d); chk(d == 0, "R1 reset ctrl", d, 0);
    bus_read(3'd1, d); chk(d == 0, "R7 reset status", d, 0);
    chk(irq == 0, "R10 reset irq", irq, 0);
    chk(sck_out == 0, "R2 reset sck idle low", sck_out, 0);
  endtask

  task automatic t_regs();
    logic [DW-1:0] d;
    bus_write(3'd0, 8'h1A);
    bus_read(3'd0, d); chk(d == 8'h1A, "R1 ctrl readback", d, 8'h1A);
    bus_write(3'd0, 8'h00);
    bus_write(3'd2, 8'hFF);
    bus_read(3'd2, d); chk(d == 8'h7F, "R1 divider 7 bits", d, 8'h7F);
  endtask

  task automatic t_master_ph1();
    logic [DW-1:0] d;
    loopback = 1'b1;
    bus_write(3'd2, 8'd3);
    bus_write(3'd0, 8'h0F);
    bus_write(3'd3, 8'hA5);
    wait_status(0, 1'b1, "R7 completion seen");
    chk(mon_pos == 8'hA5, "R4 phase1 rising-edge data MSB first", mon_pos, 8'hA5);
    bus_read(3'd5, d); chk(d == 8'hA5, "R9 debug copy", d, 8'hA5);
    bus_read(3'd1, d); chk(d == 8'h01, "R9 flags kept after debug read", d, 8'h01);
    chk(irq == 1, "R10 completion irq", irq, 1);
    bus_read(3'd4, d); chk(d == 8'hA5, "R3 loopback receive", d, 8'hA5);
    bus_read(3'd1, d); chk(d == 8'h00, "R7 receive read clears", d, 0);
    chk(irq == 0, "R10 irq drops", irq, 0);
  endtask

  task automatic t_master_ph0();
    logic [DW-1:0] d;
    bus_write(3'd0, 8'h05);
    bus_write(3'd3, 8'h3C);
    wait_status(0, 1'b1, "R7 completion phase0");
    chk(mon_neg == 8'h3C, "R4 phase0 falling-edge data", mon_neg, 8'h3C);
    chk(irq == 0, "R10 irq disabled", irq, 0);
    bus_read(3'd4, d); chk(d == 8'h3C, "R3 phase0 loopback", d, 8'h3C);
  endtask

  task automatic t_period(input int dv);
    logic [DW-1:0] d;
    int per;
    bus_write(3'd0, 8'h07);
    bus_write(3'd2, DW'(dv));
    bus_write(3'd3, 8'h69);
    wait_status(0, 1'b1, "R2 completion");
    per = int'((rt[(rise_cnt - 1) % 64] - rt[(rise_cnt - 2) % 64]) / TCLK);
    chk(per == bit_clocks(dv), "R2 bit period", per, bit_clocks(dv));
    bus_read(3'd4, d);
  endtask

  task automatic t_txen();
    logic [DW-1:0] d;
    int r0;
    bus_write(3'd2, 8'd3);
    bus_write(3'd0, 8'h03);
    r0 = rise_cnt;
    bus_write(3'd3, 8'h5A);
    repeat (200) @(negedge clk);
    bus_read(3'd1, d); chk(d == 8'h04, "R5 R6 pending while disabled", d, 8'h04);
    chk(rise_cnt == r0, "R6 no clock while disabled", rise_cnt - r0, 0);
    bus_write(3'd0, 8'h07);
    wait_status(0, 1'b1, "R6 starts on enable");
    bus_read(3'd4, d); chk(d == 8'h5A, "R6 data after enable", d, 8'h5A);
  endtask

  task automatic t_b2b_ovr();
    logic [DW-1:0] d;
    int r0, gap;
    bus_write(3'd2, 8'd3);
    bus_write(3'd0, 8'h17);
    r0 = rise_cnt;
    bus_write(3'd3, 8'h11);
    wait_status(2, 1'b0, "R5 full clears on load");
    bus_write(3'd3, 8'h22);
    bus_read(3'd1, d); chk(d[2] == 1'b1, "R5 full while shifting", d, 8'h04);
    wait_status(1, 1'b1, "R8 overrun seen");
    chk(rise_cnt - r0 == 16, "R5 two characters", rise_cnt - r0, 16);
    gap = int'((rt[(r0 + 15) % 64] - rt[r0 % 64]) / TCLK);
    chk(gap == 15 * bit_clocks(3), "R5 no idle gap", gap, 15 * bit_clocks(3));
    chk(irq == 1, "R10 overrun irq", irq, 1);
    bus_read(3'd5, d); chk(d == 8'h22, "R8 newest kept", d, 8'h22);
    bus_read(3'd1, d); chk(d == 8'h03, "R9 flags after debug read", d, 8'h03);
    bus_read(3'd4, d); chk(d == 8'h22, "R8 receive newest", d, 8'h22);
    bus_read(3'd1, d); chk(d == 8'h00, "R7 R8 read clears both", d, 0);
    chk(irq == 0, "R10 irq clears", irq, 0);
  endtask

  task automatic t_slave();
    logic [DW-1:0] d, got;
    logic [DW-1:0] m = 8'h96;
    int r0;
    loopback = 1'b0;
    bus_write(3'd0, 8'h0A);
    bus_write(3'd3, 8'hC3);
    repeat (5) @(negedge clk);
    r0 = rise_cnt;
    got = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      sdi_drv = m[i];
      repeat (8) @(negedge clk);
      got = {got[DW-2:0], sdo};
      sck_in = 1'b1;
      repeat (8) @(negedge clk);
      sck_in = 1'b0;
    end
    repeat (10) @(negedge clk);
    chk(got == 8'hC3, "R11 slave transmit", got, 8'hC3);
    bus_read(3'd1, d); chk(d == 8'h01, "R11 slave completion", d, 8'h01);
    chk(irq == 1, "R10 slave irq", irq, 1);
    bus_read(3'd4, d); chk(d == m, "R11 slave receive", d, m);
    chk(rise_cnt == r0 && sck_out == 0, "R11 own clock low", rise_cnt - r0, 0);
  endtask

  initial begin
    #(TCLK * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_master_ph1();
    t_master_ph0();
    t_period(5);
    t_period(1);
    t_txen();
    t_b2b_ovr();
    t_slave();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule